// File: doc/BRIEF.md
# Oscillator Trim Controller with Sync-Referenced Error Counter

This block measures a local oscillator, which also clocks the block, against a slower reference sync pulse and steers a 6-bit trim code toward the target frequency. A reload counter is loaded with (target cycles per sync period) − 1 at every sync event. It counts down, crosses zero at the instant the next sync is expected, then counts up. At each sync the counter magnitude and its direction are captured. The magnitude is graded against a programmable limit, and when automatic trimming is on the grade moves the trim code by 0, 1 or 2 steps.

The sync comes from one of three inputs, chosen by a source field. It passes through a polarity select and a power-of-two prescaler, and software can also inject a sync event. Status flags are cleared by writing 1 to them, and each of four flags can raise the single interrupt line through its own enable. Software uses a small register port with four addresses: control, configuration, status and clear. Reads on that port are combinational from `addr`.

Top module: `clk_trim_ctrl`

## Requirements
- R1: Each sync event reloads the counter from the reload field. The same event captures the counter magnitude into bits [31:16] of status, and into `errCapture`. It captures direction into status bit 7 and `errDirUp` (1 means the counter had passed zero). With an event P cycles after the previous reload and a reload value R, the capture is R+1−P with direction 0 when P ≤ R+1, and P−R−1 with direction 1 otherwise.
- R2: At a sync event, a capture below the limit sets the ok flag (status bit 0) and leaves the trim alone. A capture from the limit up to, but not including, three times the limit sets the warning flag (bit 1) and steps the trim by 1. A capture of three times the limit or more sets the warning flag and steps the trim by 2. Automatic trimming steps up on direction 0 and down on direction 1.
- R3: A step that would leave 0..63 saturates the trim at the bound and sets the trim-overflow flag (bit 6). A step that lands exactly on a bound does not set that flag.
- R4: Whenever the down-counting counter is at zero, the expected-sync flag (bit 3) is set, including in the cycle a sync arrives.
- R5: With no sync, the up-counting counter stops at 128 × limit and sets the missed flag (bit 5) without trimming. A sync after that sets the sync-error flag (bit 4), reloads the counter and does not trim.
- R6: Status bit 2 is the OR of bits 4, 5 and 6. Writing 1 to bit 2 of the clear address (3) clears all three.
- R7: Writing 1 to clear bits 0, 1 and 3 clears ok, warning and expected-sync. A flag that is set and cleared in the same cycle ends up set.
- R8: `irq` is high while any flag is set whose enable bit in control is set. The enables are: bit 4 for ok, bit 5 for warning, bit 6 for error and bit 7 for expected-sync.
- R9: The trim code resets to 32. Control bits [13:8] write it only while automatic trimming (control bit 1) is off before the write.
- R10: The configuration at address 1 resets to 0x2022BB7F. Its fields are reload [15:0], limit [23:16], prescale [26:24], source [29:28] and polarity [31]. Writes to it are ignored while the counter enable (control bit 0) is set.
- R11: Source 0 selects `syncPin`, source 1 selects `syncXtal` and source 2 selects `syncSof`. Polarity 0 acts on rising edges and polarity 1 acts on falling edges. Edges on unselected inputs have no effect.
- R12: A prescale value n produces one sync event per 2^n active edges, counted from the moment the counter is enabled.
- R13: Writing 1 to control bit 2 together with the enable produces one sync event in the following cycle. The bit always reads back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock being trimmed |
| rstN | input | 1 | Active-low reset |
| syncPin | input | 1 | Sync from an external pin |
| syncXtal | input | 1 | Sync from the low-speed crystal |
| syncSof | input | 1 | Sync from the USB start-of-frame |
| wrEn | input | 1 | Register write strobe |
| addr | input | 2 | Register address for both reads and writes |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `addr` |
| trimCode | output | 6 | Oscillator trim code |
| errCapture | output | 16 | Captured error magnitude |
| errDirUp | output | 1 | Captured counter direction |
| irq | output | 1 | Interrupt request |

## Verification
A sync event can land in the same cycle as a write-1-to-clear of the flag that the event sets. It can also land in the same cycle as the counter reaching zero. The bench provokes the first case by raising the pin on the same falling edge that issues the clear write, with the sync period equal to reload+1. It then expects the ok flag to survive, and expects the expected-sync flag to be set in that same cycle as well. A sweep over sync periods on both sides of the target checks every capture, direction, grade and trim step against arithmetic done in the bench.

// File: rtl/clk_trim_pkg.sv
package clk_trim_pkg;
  localparam int CNT_W   = 16;
  localparam int LIM_W   = 8;
  localparam int TRIM_W  = 6;
  localparam int DIV_W   = 3;
  localparam int PRE_W   = (1 << DIV_W) - 1;
  localparam int MISS_SH = 7;

  localparam logic [CNT_W-1:0]  RELOAD_RST = 16'hBB7F;
  localparam logic [LIM_W-1:0]  LIMIT_RST  = 8'h22;
  localparam logic [TRIM_W-1:0] TRIM_RST   = 6'd32;

  localparam logic [1:0] SRC_PIN  = 2'd0;
  localparam logic [1:0] SRC_XTAL = 2'd1;
  localparam logic [1:0] SRC_SOF  = 2'd2;

  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_CFG  = 2'd1;
  localparam logic [1:0] REG_STAT = 2'd2;
  localparam logic [1:0] REG_CLR  = 2'd3;

  localparam logic [1:0] GRADE_OK    = 2'd0;
  localparam logic [1:0] GRADE_SMALL = 2'd1;
  localparam logic [1:0] GRADE_BIG   = 2'd2;

  typedef struct packed {
    logic [CNT_W-1:0] reload;
    logic [LIM_W-1:0] limit;
    logic [DIV_W-1:0] div;
    logic [1:0]       src;
    logic             pol;
  } cfg_t;

  typedef struct packed {
    logic cntEn;
    logic swPulse;
  } ctlStrobe_t;

  typedef struct packed {
    logic             evt;
    logic             lateSync;
    logic             zeroHit;
    logic             missHit;
    logic [1:0]       grade;
    logic             dirUp;
    logic [CNT_W-1:0] mag;
  } dpResult_t;

  typedef struct packed {
    logic trimOvf;
    logic syncMiss;
    logic syncErr;
    logic esync;
    logic warn;
    logic ok;
  } flags_t;
endpackage

// File: rtl/clk_trim_dp.sv
module clk_trim_dp
  import clk_trim_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       syncPin,
  input  logic       syncXtal,
  input  logic       syncSof,
  input  cfg_t       cfg,
  input  ctlStrobe_t ctl,
  output dpResult_t  res
);
  logic selLvl, lvl, lvlQ, edgeHit, divFire, syncEvt;
  logic [PRE_W-1:0] divCnt, divMask;
  logic [CNT_W-1:0] cnt, missLim, limExt, lim3;
  logic upQ, missQ, zeroHit, missHit;

  // sync conditioning: source select, polarity, edge detect, prescale
  always_comb begin
    case (cfg.src)
      SRC_PIN:  selLvl = syncPin;
      SRC_XTAL: selLvl = syncXtal;
      SRC_SOF:  selLvl = syncSof;
      default:  selLvl = 1'b0;
    endcase
  end

  assign lvl     = selLvl ^ cfg.pol;
  assign edgeHit = lvl & ~lvlQ;
  assign divMask = ~({PRE_W{1'b1}} << cfg.div);
  assign divFire = edgeHit && ((divCnt & divMask) == divMask);
  assign syncEvt = ctl.cntEn && (divFire || ctl.swPulse);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lvlQ   <= 1'b0;
      divCnt <= '0;
    end else begin
      lvlQ <= lvl;
      if (!ctl.cntEn)   divCnt <= '0;
      else if (edgeHit) divCnt <= divFire ? '0 : divCnt + 1'b1;
    end
  end

  // reload counter: down to zero, then up until the miss ceiling
  assign missLim = CNT_W'({cfg.limit, {MISS_SH{1'b0}}});
  assign zeroHit = ctl.cntEn && !upQ && !missQ && (cnt == '0);
  assign missHit = ctl.cntEn && upQ && !missQ && !syncEvt && (cnt == missLim);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt   <= RELOAD_RST;
      upQ   <= 1'b0;
      missQ <= 1'b0;
    end else if (!ctl.cntEn || syncEvt) begin
      cnt   <= cfg.reload;
      upQ   <= 1'b0;
      missQ <= 1'b0;
    end else if (missHit) begin
      missQ <= 1'b1;
    end else if (!missQ) begin
      if (upQ)          cnt <= cnt + 1'b1;
      else if (zeroHit) begin
        upQ <= 1'b1;
        cnt <= CNT_W'(1);
      end else          cnt <= cnt - 1'b1;
    end
  end

  // grading of the present magnitude against limit and 3 x limit
  assign limExt = CNT_W'(cfg.limit);
  assign lim3   = limExt + (limExt << 1);

  always_comb begin
    res.evt      = syncEvt;
    res.lateSync = syncEvt && missQ;
    res.zeroHit  = zeroHit;
    res.missHit  = missHit;
    res.dirUp    = upQ;
    res.mag      = cnt;
    if (cnt < limExt)    res.grade = GRADE_OK;
    else if (cnt < lim3) res.grade = GRADE_SMALL;
    else                 res.grade = GRADE_BIG;
  end
endmodule

// File: rtl/clk_trim_ctl.sv
module clk_trim_ctl
  import clk_trim_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        addr,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  input  dpResult_t         res,
  output cfg_t              cfg,
  output ctlStrobe_t        ctl,
  output flags_t            flags,
  output logic [TRIM_W-1:0] trimCode,
  output logic [CNT_W-1:0]  capOut,
  output logic              dirOut,
  output logic              irq
);
  localparam logic [TRIM_W:0] TRIM_MAX = (TRIM_W+1)'((1 << TRIM_W) - 1);

  logic cntEnQ, autoTrimQ, swPulseQ, dirQ;
  logic [3:0] ieQ;
  logic [TRIM_W-1:0] trimQ, stepAmt, trimNext;
  logic [TRIM_W:0] trimSum;
  logic [CNT_W-1:0] capQ;
  logic trimSat, ctrlWr, cfgWr, clrWr, gradedEvt, doStep, errAny;
  flags_t setV, clrV;
  logic unusedBits;

  assign ctrlWr = wrEn && (addr == REG_CTRL);
  assign cfgWr  = wrEn && (addr == REG_CFG);
  assign clrWr  = wrEn && (addr == REG_CLR);
  assign unusedBits = ^{wrData[31:14], wrData[3], wrData[27], wrData[30]};

  // trim stepping with saturation at both bounds
  always_comb begin
    stepAmt  = (res.grade == GRADE_BIG) ? TRIM_W'(2) : TRIM_W'(1);
    trimSum  = {1'b0, trimQ} + {1'b0, stepAmt};
    trimSat  = 1'b0;
    trimNext = trimQ;
    if (res.dirUp) begin
      if (trimQ < stepAmt) begin
        trimNext = '0;
        trimSat  = 1'b1;
      end else trimNext = trimQ - stepAmt;
    end else if (trimSum > TRIM_MAX) begin
      trimNext = TRIM_MAX[TRIM_W-1:0];
      trimSat  = 1'b1;
    end else trimNext = trimSum[TRIM_W-1:0];
  end

  assign gradedEvt = res.evt && !res.lateSync;
  assign doStep    = gradedEvt && autoTrimQ && (res.grade != GRADE_OK);

  always_comb begin
    setV.ok       = gradedEvt && (res.grade == GRADE_OK);
    setV.warn     = gradedEvt && (res.grade != GRADE_OK);
    setV.esync    = res.zeroHit;
    setV.syncErr  = res.lateSync;
    setV.syncMiss = res.missHit;
    setV.trimOvf  = doStep && trimSat;
    clrV.ok       = clrWr && wrData[0];
    clrV.warn     = clrWr && wrData[1];
    clrV.syncErr  = clrWr && wrData[2];
    clrV.syncMiss = clrWr && wrData[2];
    clrV.trimOvf  = clrWr && wrData[2];
    clrV.esync    = clrWr && wrData[3];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntEnQ    <= 1'b0;
      autoTrimQ <= 1'b0;
      swPulseQ  <= 1'b0;
      ieQ       <= '0;
      trimQ     <= TRIM_RST;
      cfg       <= '{reload: RELOAD_RST, limit: LIMIT_RST, div: '0, src: SRC_SOF, pol: 1'b0};
      capQ      <= '0;
      dirQ      <= 1'b0;
      flags     <= '0;
    end else begin
      swPulseQ <= ctrlWr && wrData[2];
      if (ctrlWr) begin
        cntEnQ    <= wrData[0];
        autoTrimQ <= wrData[1];
        ieQ       <= wrData[7:4];
        if (!autoTrimQ) trimQ <= wrData[13:8];
      end
      if (doStep) trimQ <= trimNext;
      if (cfgWr && !cntEnQ)
        cfg <= '{reload: wrData[15:0], limit: wrData[23:16], div: wrData[26:24],
                 src: wrData[29:28], pol: wrData[31]};
      if (res.evt) begin
        capQ <= res.mag;
        dirQ <= res.dirUp;
      end
      flags <= (flags & ~clrV) | setV;
    end
  end

  assign errAny    = flags.syncErr | flags.syncMiss | flags.trimOvf;
  assign ctl       = '{cntEn: cntEnQ, swPulse: swPulseQ};
  assign trimCode  = trimQ;
  assign capOut    = capQ;
  assign dirOut    = dirQ;
  assign irq       = |(ieQ & {flags.esync, errAny, flags.warn, flags.ok});

  always_comb begin
    case (addr)
      REG_CTRL: rdData = {18'd0, trimQ, ieQ, 2'b00, autoTrimQ, cntEnQ};
      REG_CFG:  rdData = {cfg.pol, 1'b0, cfg.src, 1'b0, cfg.div, cfg.limit, cfg.reload};
      REG_STAT: rdData = {capQ, 8'd0, dirQ, flags.trimOvf, flags.syncMiss, flags.syncErr,
                          flags.esync, errAny, flags.warn, flags.ok};
      default:  rdData = 32'd0;
    endcase
  end
endmodule

// File: rtl/clk_trim_ctrl.sv
module clk_trim_ctrl
  import clk_trim_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              syncPin,
  input  logic              syncXtal,
  input  logic              syncSof,
  input  logic              wrEn,
  input  logic [1:0]        addr,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  output logic [TRIM_W-1:0] trimCode,
  output logic [CNT_W-1:0]  errCapture,
  output logic              errDirUp,
  output logic              irq
);
  cfg_t       cfgS;
  ctlStrobe_t ctlS;
  dpResult_t  dpRes;
  flags_t     flagS;

  clk_trim_dp u_dp (
    .clk(clk), .rstN(rstN), .syncPin(syncPin), .syncXtal(syncXtal), .syncSof(syncSof),
    .cfg(cfgS), .ctl(ctlS), .res(dpRes)
  );

  clk_trim_ctl u_ctl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData), .rdData(rdData),
    .res(dpRes), .cfg(cfgS), .ctl(ctlS), .flags(flagS), .trimCode(trimCode),
    .capOut(errCapture), .dirOut(errDirUp), .irq(irq)
  );
endmodule

// File: rtl/clk_trim_chk.sv
module clk_trim_chk
  import clk_trim_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [1:0]        addr,
  input logic [3:0]        wrLow,
  input logic              irq,
  input logic [TRIM_W-1:0] trimCode,
  input logic              cntEn,
  input cfg_t              cfg,
  input logic              evt,
  input logic              lateSync,
  input logic              ovfFlag,
  input logic              serrFlag
);
  p_trim_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!evt && !(wrEn && addr == REG_CTRL)) |=> $stable(trimCode));

  p_trim_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (evt && !(wrEn && addr == REG_CTRL)) |=>
      (((trimCode > $past(trimCode)) ? (trimCode - $past(trimCode))
                                     : ($past(trimCode) - trimCode)) <= TRIM_W'(2)));

  p_ovf_cause_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovfFlag) |-> $past(evt));

  p_late_err_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(serrFlag) |-> $past(lateSync));

  p_irq_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!cntEn && wrEn && addr == REG_CLR && wrLow == 4'hF) |=> !irq);

  p_cfg_lock_r10: assert property (@(posedge clk) disable iff (!rstN)
    cntEn |=> $stable(cfg));

  p_sw_event_r13: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == REG_CTRL && wrLow[2] && wrLow[0]) |=> evt);
endmodule

bind clk_trim_ctrl clk_trim_chk u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrLow(wrData[3:0]), .irq(irq),
  .trimCode(trimCode), .cntEn(ctlS.cntEn), .cfg(cfgS), .evt(dpRes.evt),
  .lateSync(dpRes.lateSync), .ovfFlag(flagS.trimOvf), .serrFlag(flagS.syncErr)
);

// File: tb/sim_clk_trim_ctrl.sv
`timescale 1ns/1ps
module sim_clk_trim_ctrl;
  logic clk = 1'b0, rstN = 1'b0;
  logic syncPin = 1'b0, syncXtal = 1'b0, syncSof = 1'b0;
  logic wrEn = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [31:0] wrData = '0, rdData;
  logic [5:0] trimCode;
  logic [15:0] errCapture;
  logic errDirUp, irq;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  clk_trim_ctrl u0 (.*);

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); wrEn = 1; addr = a; wrData = d;
    @(negedge clk); wrEn = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    addr = a; #1; d = rdData;
  endtask

  task automatic drive(input int sel, input logic v);
    if (sel == 0) syncPin = v; else if (sel == 1) syncXtal = v; else syncSof = v;
  endtask

  // one-cycle pulse whose event edge lands gap cycles after the previous reference edge
  task automatic pulse(input int sel, input logic act, input int gap);
    repeat (gap - 1) @(negedge clk);
    drive(sel, act);
    @(negedge clk);
    drive(sel, ~act);
  endtask

  function automatic logic [31:0] cfgWord(input logic pol, input logic [1:0] src,
      input logic [2:0] dv, input logic [7:0] lim, input logic [15:0] rl);
    return {pol, 1'b0, src, 1'b0, dv, lim, rl};
  endfunction

  task automatic prep(input int t, input logic [31:0] mode);
    wr(2'd0, 32'd0);
    wr(2'd0, 32'(t) << 8);
    wr(2'd3, 32'hF);
    wr(2'd0, mode | (32'(t) << 8));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // reset state
    chk("R9 reset trim", 32'(trimCode), 32);
    rd(2'd1, v); chk("R10 reset cfg", v, 32'h2022BB7F);
    rd(2'd2, v); chk("R6 reset status", v, 0);
    chk("R8 reset irq", 32'(irq), 0);

    // R10 write protect
    wr(2'd1, cfgWord(0, 2'd0, 3'd0, 8'd4, 16'd99));
    rd(2'd1, v); chk("R10 cfg write", v, cfgWord(0, 2'd0, 3'd0, 8'd4, 16'd99));
    wr(2'd0, 32'd1);
    wr(2'd1, cfgWord(1, 2'd1, 3'd5, 8'd9, 16'd7));
    rd(2'd1, v); chk("R10 cfg locked", v, cfgWord(0, 2'd0, 3'd0, 8'd4, 16'd99));

    // R1 R2 R4 sweep of sync period around reload+1 = 100, limit 4
    for (int p = 85; p <= 115; p++) begin
      int d, e, st, tExp;
      bit up;
      logic [31:0] sExp;
      d = p - 100; up = (d > 0); e = up ? d : -d;
      st = (e < 4) ? 0 : (e < 12) ? 1 : 2;
      tExp = up ? 32 - st : 32 + st;
      sExp = {16'(e), 8'd0, up, 3'b000, (d >= 0), 1'b0, (st != 0), (st == 0)};
      prep(32, 32'h3);
      pulse(0, 1, p);
      rd(2'd2, v);
      chk($sformatf("R1 R2 R4 status p=%0d", p), v, sExp);
      chk($sformatf("R2 trim p=%0d", p), 32'(trimCode), 32'(tExp));
      chk($sformatf("R1 capture port p=%0d", p), {15'd0, errDirUp, errCapture}, {15'd0, up, 16'(e)});
    end

    // R3 R6 saturation
    prep(63, 32'h3); pulse(0, 1, 85);
    chk("R3 sat high trim", 32'(trimCode), 63);
    rd(2'd2, v); chk("R3 R6 sat high flags", 32'(v[6:0]), 32'h46);
    wr(2'd3, 32'h4);
    rd(2'd2, v); chk("R6 err clear", 32'(v[6:0]), 32'h02);
    prep(1, 32'h3); pulse(0, 1, 115);
    chk("R3 sat low trim", 32'(trimCode), 0);
    rd(2'd2, v); chk("R3 sat low flags", 32'(v[6:0]), 32'h4E);
    prep(62, 32'h3); pulse(0, 1, 95);
    chk("R3 exact bound trim", 32'(trimCode), 63);
    rd(2'd2, v); chk("R3 exact bound no ovf", 32'(v[6:0]), 32'h02);

    // R7 R8 set beats clear, interrupt masking
    prep(32, 32'h1);
    repeat (99) @(negedge clk);
    syncPin = 1; wrEn = 1; addr = 2'd3; wrData = 32'h1;
    @(negedge clk); syncPin = 0; wrEn = 0;
    rd(2'd2, v); chk("R7 R4 set wins over clear", 32'(v[3:0]), 32'h9);
    chk("R8 irq masked", 32'(irq), 0);
    wr(2'd0, 32'h11 | (32 << 8));
    chk("R8 irq enabled", 32'(irq), 1);
    wr(2'd3, 32'h1);
    rd(2'd2, v); chk("R7 ok cleared", 32'(v[0]), 0);
    chk("R8 irq after clear", 32'(irq), 0);

    // R9 trim writes ignored under automatic trimming
    prep(20, 32'h0);
    wr(2'd0, 32'h2 | (20 << 8));
    wr(2'd0, 32'h2 | (45 << 8));
    chk("R9 trim ignored", 32'(trimCode), 20);
    wr(2'd0, 32'h0 | (45 << 8));
    chk("R9 trim ignored on disable write", 32'(trimCode), 20);
    wr(2'd0, 32'h0 | (45 << 8));
    chk("R9 trim written", 32'(trimCode), 45);

    // R12 prescaler: 2^n edges, 10 cycles apart
    for (int n = 0; n <= 4; n++) begin
      int per, e;
      bit up;
      wr(2'd0, 32'd0);
      wr(2'd1, cfgWord(0, 2'd0, 3'(n), 8'd4, 16'd99));
      prep(32, 32'h1);
      for (int k = 0; k < (1 << n); k++) pulse(0, 1, 10);
      per = 10 * (1 << n); up = (per > 100); e = up ? per - 100 : 100 - per;
      chk($sformatf("R12 capture n=%0d", n), {15'd0, errDirUp, errCapture}, {15'd0, up, 16'(e)});
    end

    // R11 crystal source, falling edge; pin ignored
    wr(2'd0, 32'd0);
    syncXtal = 1;
    wr(2'd1, cfgWord(1, 2'd1, 3'd0, 8'd4, 16'd99));
    prep(32, 32'h1);
    pulse(0, 1, 50);
    rd(2'd2, v); chk("R11 unselected pin ignored", 32'(v[1:0]), 0);
    pulse(1, 0, 50);
    rd(2'd2, v); chk("R11 falling xtal event", {v[31:16], 14'd0, v[1:0]}, 32'h1);
    syncXtal = 0;

    // R13 software sync
    wr(2'd0, 32'd0);
    wr(2'd1, cfgWord(0, 2'd0, 3'd0, 8'd1, 16'd99));
    prep(32, 32'h0);
    wr(2'd0, 32'h5);
    @(negedge clk);
    chk("R13 sw sync capture", {15'd0, errDirUp, errCapture}, 32'd99);
    rd(2'd0, v); chk("R13 sw bit reads zero", v, 32'h1);

    // R5 missed sync with limit 1 (ceiling 128), then late sync
    prep(32, 32'h3);
    repeat (240) @(negedge clk);
    rd(2'd2, v); chk("R5 R4 missed flags", 32'(v[6:0]), 32'h2C);
    pulse(0, 1, 1);
    rd(2'd2, v); chk("R5 late sync error", 32'(v[6:0]), 32'h3C);
    chk("R5 no trim", 32'(trimCode), 32);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule